// File: doc/BRIEF.md
# Local Interrupt Pin Router

This block connects a small set of local interrupt pins to the interrupt request lines of a single processor core. A control register holds a software enable bit. While that bit is clear the router is bypassed: pin 0 drives the core's external-interrupt request directly and follows the pin level. Once software sets the enable bit, each pin is handled through its own configuration entry. A rising edge on a pin is either dropped, because the entry is masked, or turned into an external-interrupt, NMI or SMI request, depending on the entry's delivery-mode field.

Requests raised in enabled mode stay latched until the core pulses the matching acknowledge input. Delivery modes the router cannot deliver raise a sticky error flag in place of a request. Routing an external interrupt or an NMI from a pin other than the one wired for it still delivers the request, but also raises a sticky warning flag. A simple register port with a write strobe and a read strobe gives access to the control register and to the per-pin entries. Any access to an address above the last pin entry is rejected and flagged.

Top module: `lpr_router`

## Requirements
- R1: After reset, all three request outputs and all three flags are 0. The control register reads 0x0000_0000 and every pin entry reads 0x0001_0000 (masked).
- R2: While control bit 8 (enable) is clear, req_ext equals the level pin 0 had at the previous clock edge. No other pin affects any request.
- R3: Address 0 is the control register and address 1+i is the entry for pin i. Read data appears the cycle after a read strobe. A write or read to an address above NPINS changes no register, returns 0 on a read, and sets err_param.
- R4: With enable set, a rising edge on a pin whose entry is unmasked raises a request in the cycle after the edge is sampled. Entry bits 10:8 select the request: 111 raises req_ext, 100 raises req_nmi, 010 raises req_smi.
- R5: A pin edge whose entry has bit 16 (mask) set raises no request and no flag.
- R6: In enabled mode, each request stays high until its own acknowledge input is high at a clock edge, and is low from the next cycle on. A new set in the same cycle as an acknowledge wins. A pin held high does not raise the request again.
- R7: Modes 000, 101, 001, 011 and 110 on an unmasked edge raise no request and set err_mode.
- R8: Mode 111 on any pin other than pin 0, or mode 100 on any pin other than pin 1, delivers the request and also sets warn_wiring. The legal pairings leave warn_wiring at 0.
- R9: err_mode, warn_wiring and err_param stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address: 0 is control, 1+i is the pin i entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_lvl | input | NPINS | Local interrupt pin levels |
| ack_ext | input | 1 | Acknowledge for the external-interrupt request |
| ack_nmi | input | 1 | Acknowledge for the NMI request |
| ack_smi | input | 1 | Acknowledge for the SMI request |
| req_ext | output | 1 | External-interrupt request to the core |
| req_nmi | output | 1 | NMI request to the core |
| req_smi | output | 1 | SMI request to the core |
| err_mode | output | 1 | Sticky flag: an unsupported delivery mode was hit |
| warn_wiring | output | 1 | Sticky flag: a request type arrived on an unexpected pin |
| err_param | output | 1 | Sticky flag: a register access named an invalid index |

## Verification
Pin stimulus is applied in three patterns.
- **Level changes with enable clear.** These show that pin 0 is followed level for level, and that pin 1 is ignored.
- **Isolated rising edges with enable set.** Each mode value is tried on each pin. This separates the three request types, the unsupported modes and the wiring mismatches.
- **A pin held high across an acknowledge, and an edge coinciding with an acknowledge.** These separate edge detection from level detection, and show which of set and clear has priority.

Masked edges on both pins at once confirm that the mask suppresses flags as well as requests.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef logic [31:0] word_t;

  localparam int MASK_BIT = 16;
  localparam int MODE_LO  = 8;
  localparam int MODE_W   = 3;
  localparam int EN_BIT   = 8;

  localparam word_t ENT_RST = 32'h0001_0000;
  localparam word_t CTL_RST = 32'h0000_0000;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED = 3'b000,
    DM_SMI   = 3'b010,
    DM_NMI   = 3'b100,
    DM_INIT  = 3'b101,
    DM_EXT   = 3'b111
  } dmode_e;
endpackage

// File: rtl/lpr_regfile.sv
module lpr_regfile
  import lpr_pkg::*;
#(
  parameter int NPINS  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  word_t             reg_wdata,
  output word_t             reg_rdata,
  output logic              en_o,
  output logic              mask_o [NPINS],
  output logic [MODE_W-1:0] mode_o [NPINS],
  output logic              err_param
);
  localparam int NREG = NPINS + 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREG - 1);

  word_t ctl_q;
  word_t ent_q [NPINS];
  word_t rd_sel;
  logic  bad_addr;

  assign bad_addr = reg_addr > LAST;

  always_ff @(posedge clk) begin
    if (rst)                          ctl_q <= CTL_RST;
    else if (reg_wr && reg_addr == '0) ctl_q <= reg_wdata;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                                       ent_q[i] <= ENT_RST;
      else if (reg_wr && reg_addr == ADDR_W'(i + 1)) ent_q[i] <= reg_wdata;
    end
    assign mask_o[i] = ent_q[i][MASK_BIT];
    assign mode_o[i] = ent_q[i][MODE_LO +: MODE_W];

    a_r3_ent_untouched: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr != ADDR_W'(i + 1)) |=> $stable(ent_q[i]));
  end

  assign en_o = ctl_q[EN_BIT];

  always_comb begin
    rd_sel = '0;
    if (reg_addr == '0) rd_sel = ctl_q;
    for (int i = 0; i < NPINS; i++)
      if (reg_addr == ADDR_W'(i + 1)) rd_sel = ent_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      err_param <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_sel;
      if ((reg_wr || reg_rd) && bad_addr) err_param <= 1'b1;
    end
  end

  a_r3_bad_addr_flag: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && bad_addr) |=> err_param);
  a_r3_bad_wr_ctl: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && bad_addr) |=> $stable(ctl_q));
  a_r9_param_sticky: assert property (@(posedge clk) disable iff (rst)
    err_param |=> err_param);
endmodule

// File: rtl/lpr_pin_decode.sv
module lpr_pin_decode
  import lpr_pkg::*;
#(
  parameter int PIN_IDX  = 0,
  parameter int EXT_PIN  = 0,
  parameter int NMI_PIN  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pin,
  input  logic              mask,
  input  logic [MODE_W-1:0] mode,
  output logic              hit_ext,
  output logic              hit_nmi,
  output logic              hit_smi,
  output logic              hit_bad,
  output logic              hit_warn
);
  localparam bit EXT_OK = (PIN_IDX == EXT_PIN);
  localparam bit NMI_OK = (PIN_IDX == NMI_PIN);

  logic pin_q;
  logic fire;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  assign fire = en && pin && !pin_q && !mask;

  always_comb begin
    hit_ext = 1'b0;
    hit_nmi = 1'b0;
    hit_smi = 1'b0;
    hit_bad = 1'b0;
    if (fire) begin
      case (dmode_e'(mode))
        DM_EXT:  hit_ext = 1'b1;
        DM_NMI:  hit_nmi = 1'b1;
        DM_SMI:  hit_smi = 1'b1;
        default: hit_bad = 1'b1;
      endcase
    end
    hit_warn = (hit_ext && !EXT_OK) || (hit_nmi && !NMI_OK);
  end

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    mask |-> !(hit_ext || hit_nmi || hit_smi || hit_bad));
  a_r6_no_level_refire: assert property (@(posedge clk) disable iff (rst)
    (pin && $past(pin)) |-> !(hit_ext || hit_nmi || hit_smi || hit_bad));
endmodule

// File: rtl/lpr_req_ctl.sv
module lpr_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pin0,
  input  logic set_ext,
  input  logic set_nmi,
  input  logic set_smi,
  input  logic set_bad,
  input  logic set_warn,
  input  logic ack_ext,
  input  logic ack_nmi,
  input  logic ack_smi,
  output logic req_ext,
  output logic req_nmi,
  output logic req_smi,
  output logic err_mode,
  output logic warn_wiring
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ext     <= 1'b0;
      req_nmi     <= 1'b0;
      req_smi     <= 1'b0;
      err_mode    <= 1'b0;
      warn_wiring <= 1'b0;
    end else begin
      if (!en)          req_ext <= pin0;
      else if (set_ext) req_ext <= 1'b1;
      else if (ack_ext) req_ext <= 1'b0;

      if (set_nmi)      req_nmi <= 1'b1;
      else if (ack_nmi) req_nmi <= 1'b0;

      if (set_smi)      req_smi <= 1'b1;
      else if (ack_smi) req_smi <= 1'b0;

      if (set_bad)  err_mode    <= 1'b1;
      if (set_warn) warn_wiring <= 1'b1;
    end
  end

  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    !en |=> (req_ext == $past(pin0)));
  a_r6_nmi_hold: assert property (@(posedge clk) disable iff (rst)
    (req_nmi && !ack_nmi) |=> req_nmi);
  a_r6_nmi_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_nmi && !set_nmi) |=> !req_nmi);
  a_r6_smi_hold: assert property (@(posedge clk) disable iff (rst)
    (req_smi && !ack_smi) |=> req_smi);
  a_r7_bad_flag: assert property (@(posedge clk) disable iff (rst)
    set_bad |=> err_mode);
  a_r9_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    err_mode |=> err_mode);
  a_r9_warn_sticky: assert property (@(posedge clk) disable iff (rst)
    warn_wiring |=> warn_wiring);
endmodule

// File: rtl/lpr_router.sv
module lpr_router
  import lpr_pkg::*;
#(
  parameter int NPINS  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              ack_ext,
  input  logic              ack_nmi,
  input  logic              ack_smi,
  output logic              req_ext,
  output logic              req_nmi,
  output logic              req_smi,
  output logic              err_mode,
  output logic              warn_wiring,
  output logic              err_param
);
  logic              en;
  logic              mask [NPINS];
  logic [MODE_W-1:0] mode [NPINS];
  logic [NPINS-1:0]  h_ext, h_nmi, h_smi, h_bad, h_warn;

  lpr_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_o      (en),
    .mask_o    (mask),
    .mode_o    (mode),
    .err_param (err_param)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    lpr_pin_decode #(.PIN_IDX(i), .EXT_PIN(0), .NMI_PIN(1)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .pin      (pin_lvl[i]),
      .mask     (mask[i]),
      .mode     (mode[i]),
      .hit_ext  (h_ext[i]),
      .hit_nmi  (h_nmi[i]),
      .hit_smi  (h_smi[i]),
      .hit_bad  (h_bad[i]),
      .hit_warn (h_warn[i])
    );
  end

  lpr_req_ctl u_req (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .pin0        (pin_lvl[0]),
    .set_ext     (|h_ext),
    .set_nmi     (|h_nmi),
    .set_smi     (|h_smi),
    .set_bad     (|h_bad),
    .set_warn    (|h_warn),
    .ack_ext     (ack_ext),
    .ack_nmi     (ack_nmi),
    .ack_smi     (ack_smi),
    .req_ext     (req_ext),
    .req_nmi     (req_nmi),
    .req_smi     (req_smi),
    .err_mode    (err_mode),
    .warn_wiring (warn_wiring)
  );

  a_r4_enabled_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (en && !req_nmi && $past(en) && pin_lvl == $past(pin_lvl) && !$rose(req_nmi)) |=> (req_nmi == 1'b0 || $past(pin_lvl) != 0));
endmodule

// File: tb/sim_lpr_router.sv
`timescale 1ns/1ps
module sim_lpr_router;
  localparam int NPINS  = 2;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [NPINS-1:0]  pin_lvl;
  logic              ack_ext, ack_nmi, ack_smi;
  logic              req_ext, req_nmi, req_smi;
  logic              err_mode, warn_wiring, err_param;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lpr_router #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_lvl(pin_lvl),
    .ack_ext(ack_ext), .ack_nmi(ack_nmi), .ack_smi(ack_smi),
    .req_ext(req_ext), .req_nmi(req_nmi), .req_smi(req_smi),
    .err_mode(err_mode), .warn_wiring(warn_wiring), .err_param(err_param)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    pin_lvl = '0; ack_ext = 0; ack_nmi = 0; ack_smi = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_reqs(input string rq, input logic [2:0] exp);
    chk(rq, "{ext,nmi,smi}", {29'd0, req_ext, req_nmi, req_smi}, {29'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk_reqs("R1", 3'b000);
    chk("R1", "flags", {29'd0, err_mode, warn_wiring, err_param}, 0);
    rd(0, d); chk("R1", "ctl", d, 32'h0);
    rd(1, d); chk("R1", "entry0", d, 32'h0001_0000);
    rd(2, d); chk("R1", "entry1", d, 32'h0001_0000);
  endtask

  task automatic t_bypass();
    do_reset();
    pin_lvl = 2'b01; tick();
    chk_reqs("R2", 3'b100);
    pin_lvl = 2'b10; tick();
    chk_reqs("R2", 3'b000);
    pin_lvl = 2'b11; tick();
    chk_reqs("R2", 3'b100);
    pin_lvl = 2'b00; tick();
    chk_reqs("R2", 3'b000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(1, 32'h0000_0700); rd(1, d); chk("R3", "entry0 rb", d, 32'h0000_0700);
    wr(2, 32'h0000_0400); rd(2, d); chk("R3", "entry1 rb", d, 32'h0000_0400);
    wr(0, 32'h0000_0100); rd(0, d); chk("R3", "ctl rb", d, 32'h0000_0100);
    chk("R3", "err_param clean", {31'd0, err_param}, 0);
    wr(3, 32'hFFFF_FFFF);
    chk("R3", "err_param bad wr", {31'd0, err_param}, 1);
    rd(0, d); chk("R3", "ctl kept", d, 32'h0000_0100);
    rd(1, d); chk("R3", "entry0 kept", d, 32'h0000_0700);
    rd(2, d); chk("R3", "entry1 kept", d, 32'h0000_0400);
    do_reset();
    rd(5, d);
    chk("R3", "bad rd data", d, 32'h0);
    chk("R3", "err_param bad rd", {31'd0, err_param}, 1);
    tick();
    chk("R9", "err_param sticky", {31'd0, err_param}, 1);
  endtask

  task automatic t_modes();
    do_reset();
    wr(1, 32'h0000_0700); wr(2, 32'h0000_0400); wr(0, 32'h0000_0100);
    pin_lvl = 2'b01; tick();
    chk_reqs("R4", 3'b100);
    pin_lvl = 2'b11; tick();
    chk_reqs("R4", 3'b110);
    chk("R8", "legal pairs no warn", {31'd0, warn_wiring}, 0);
    wr(1, 32'h0000_0200);
    pin_lvl = 2'b10; tick();
    pin_lvl = 2'b11; tick();
    chk_reqs("R4", 3'b111);
    chk("R7", "no err on good modes", {31'd0, err_mode}, 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(0, 32'h0000_0100);
    pin_lvl = 2'b11; tick();
    chk_reqs("R5", 3'b000);
    pin_lvl = 2'b00;
    wr(1, 32'h0001_0700); wr(2, 32'h0001_0000);
    pin_lvl = 2'b11; tick();
    chk_reqs("R5", 3'b000);
    chk("R5", "flags", {29'd0, err_mode, warn_wiring, err_param}, 0);
  endtask

  task automatic t_ack();
    do_reset();
    wr(2, 32'h0000_0400); wr(0, 32'h0000_0100);
    pin_lvl = 2'b10; tick();
    chk_reqs("R6", 3'b010);
    tick(); tick();
    chk_reqs("R6", 3'b010);
    ack_ext = 1; ack_smi = 1; tick(); ack_ext = 0; ack_smi = 0;
    chk_reqs("R6", 3'b010);
    ack_nmi = 1; tick(); ack_nmi = 0;
    chk_reqs("R6", 3'b000);
    tick();
    chk_reqs("R6", 3'b000);
    pin_lvl = 2'b00; tick();
    pin_lvl = 2'b10; ack_nmi = 1; tick(); ack_nmi = 0;
    chk_reqs("R6", 3'b010);
    wr(1, 32'h0000_0700);
    pin_lvl = 2'b11; tick();
    chk_reqs("R6", 3'b110);
    ack_ext = 1; tick(); ack_ext = 0;
    chk_reqs("R6", 3'b010);
  endtask

  task automatic t_bad(input logic [2:0] m);
    do_reset();
    wr(1, {21'd0, m, 8'd0}); wr(0, 32'h0000_0100);
    pin_lvl = 2'b01; tick();
    chk_reqs("R7", 3'b000);
    chk("R7", "err_mode", {31'd0, err_mode}, 1);
    pin_lvl = 2'b00; tick(); tick();
    chk("R9", "err_mode sticky", {31'd0, err_mode}, 1);
  endtask

  task automatic t_wire();
    do_reset();
    wr(2, 32'h0000_0700); wr(0, 32'h0000_0100);
    pin_lvl = 2'b10; tick();
    chk_reqs("R8", 3'b100);
    chk("R8", "ext on pin1 warn", {31'd0, warn_wiring}, 1);
    pin_lvl = 2'b00; tick();
    chk("R9", "warn sticky", {31'd0, warn_wiring}, 1);
    do_reset();
    wr(1, 32'h0000_0400); wr(0, 32'h0000_0100);
    pin_lvl = 2'b01; tick();
    chk_reqs("R8", 3'b010);
    chk("R8", "nmi on pin0 warn", {31'd0, warn_wiring}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    t_reset();
    t_bypass();
    t_regs();
    t_modes();
    t_mask();
    t_ack();
    t_bad(3'b000);
    t_bad(3'b101);
    t_bad(3'b001);
    t_bad(3'b011);
    t_bad(3'b110);
    t_wire();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule